// File: doc/BRIEF.md
# Transmit Queue Scheduler Control Registers

This block is the control register file that sits beside a transmit scheduler. It serves sixteen transmit queues that feed eight DMA channels. Software programs it through a simple write port and reads it back through an address-selected read port. The frame selection engine reads its decoded outputs: for each queue, whether the queue is active, which channel it feeds, whether it runs in scheduler-acknowledge or plain FIFO mode, and whether its window still has room.

Every per-queue status word carries its own bit-level write enables in the upper part of the written word. Software can therefore change one field, such as the channel assignment, without a read-modify-write. The shared empty-flag register has a write mask of its own in the same way. The block also holds a channel activation mask, a chain-mode select per queue, and an 8-bit write index and read index for each queue. The read index can also be stepped by the scheduler.

From these registers the block derives two helper outputs. The first says which queues may present a request: the queue is active and its channel is both valid and enabled. The second says which channels have at least one eligible, non-empty queue behind them. Several queues may share one channel. The command queue (queue 4) is held in FIFO mode whatever software writes.

Top module: `txsched_regfile`

## Requirements
- R1: A write to byte address 0x100 + 4*q, with q from 0 to 15, stores bits 9:0 of the queue status. Reading the same address returns those ten bits with bits 31:10 zero. Reset clears every status word.
- R2: Bit 10+k of a status write is the enable for data bit k (k = 0..9). A status bit changes only when its enable is 1 in the same write, and status words never change without a write.
- R3: Each status word is decoded onto the outputs as follows: bit 0 drives q_active, bits 4:1 drive the 4-bit field of q_fifo for that queue, bit 5 drives q_win_left, and bit 8 drives q_ack_mode (1 = scheduler-acknowledge, 0 = FIFO).
- R4: Bit 8 of queue 4's status word always stores and reads as 0, and q_ack_mode[4] is always 0.
- R5: Address 0x004 holds the channel activation mask in bits 7:0 (bit c enables channel c). It drives chan_en, reads back with upper bits zero, and resets to 0.
- R6: Address 0x008 holds the chain-mode select in bits 15:0 (bit q = queue q). It drives q_chain, and bits 31:16 are ignored and read as 0.
- R7: Addresses 0x040 + 4*q and 0x080 + 4*q hold the 8-bit write index and read index of queue q. A pulse on rd_adv[q] increments the read index, wrapping from 0xFF to 0x00. A software write to the read index in the same cycle takes priority over rd_adv.
- R8: Address 0x000 holds one empty flag per queue in bits 15:0 (1 = empty), all set at reset. In a write, bit 16+q enables the update of flag q.
- R9: At every clock edge, a queue whose read and write indices are equal after that edge has its empty flag set to 1. This overrides any masked write that tries to clear it.
- R10: Any other address, including any address whose bits 1:0 are not zero, reads as 0 and ignores writes.
- R11: q_eligible[q] is 1 exactly when queue q is active, its FIFO field is below 8, and the activation bit of that channel is set.
- R12: ch_pending[c] is 1 exactly when some queue that is eligible and not empty has c in its FIFO field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Byte address of the write |
| wr_data | input | 32 | Write word, including embedded enables or mask |
| rd_addr | input | 10 | Byte address of the readback |
| rd_data | output | 32 | Combinational readback word |
| rd_adv | input | 16 | Per-queue read index step from the scheduler |
| q_active | output | 16 | Per-queue active flag |
| q_fifo | output | 64 | Per-queue 4-bit channel field, queue q at bits 4q+3:4q |
| q_win_left | output | 16 | Per-queue window-left flag |
| q_ack_mode | output | 16 | Per-queue scheduler-acknowledge mode |
| q_chain | output | 16 | Per-queue chain-mode select |
| q_empty | output | 16 | Per-queue empty flag |
| chan_en | output | 8 | Channel activation mask |
| q_eligible | output | 16 | Queue may present a request to its channel |
| ch_pending | output | 8 | Channel has an eligible, non-empty queue |

## Verification
A wrong internal status word shows at the decoded outputs and at the readback port in the first cycle after the write that caused it. A wrongly merged enable bit shows as a field that changes when it should not, or stays when it should change. A corrupted index or empty flag shows on q_empty and ch_pending at the same edge as the index update, because the equality check uses the post-edge index values. The stimulus therefore pairs each masked write with a readback or an output sample taken half a cycle later. It targets the edges where two sources compete for one register: a software write racing rd_adv, and a mask clear racing an index match.

// File: rtl/txsched_regs_pkg.sv
package txsched_regs_pkg;

    localparam int ADDR_W = 10;
    localparam int STAT_W = 10;

    // Region codes taken from address bits 9:6
    localparam logic [3:0] REG_CTRL = 4'h0;
    localparam logic [3:0] REG_WIDX = 4'h1;
    localparam logic [3:0] REG_RIDX = 4'h2;
    localparam logic [3:0] REG_STAT = 4'h4;

    // Slot codes inside the control region, from address bits 5:2
    localparam logic [3:0] SLOT_EMPTY = 4'h0;
    localparam logic [3:0] SLOT_CHAN  = 4'h1;
    localparam logic [3:0] SLOT_CHAIN = 4'h2;

    typedef struct packed {
        logic       spare9;
        logic       ack;
        logic [1:0] spare7_6;
        logic       win_left;
        logic [3:0] fifo;
        logic       active;
    } qstat_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EMPTY,
        SEL_CHAN,
        SEL_CHAIN,
        SEL_WIDX,
        SEL_RIDX,
        SEL_STAT
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [3:0] q;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nq);
        dec_t d;
        d.q   = a[5:2];
        d.sel = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            unique case (a[9:6])
                REG_CTRL: begin
                    if (a[5:2] == SLOT_EMPTY)      d.sel = SEL_EMPTY;
                    else if (a[5:2] == SLOT_CHAN)  d.sel = SEL_CHAN;
                    else if (a[5:2] == SLOT_CHAIN) d.sel = SEL_CHAIN;
                end
                REG_WIDX: if (int'(a[5:2]) < nq) d.sel = SEL_WIDX;
                REG_RIDX: if (int'(a[5:2]) < nq) d.sel = SEL_RIDX;
                REG_STAT: if (int'(a[5:2]) < nq) d.sel = SEL_STAT;
                default:  d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic logic [STAT_W-1:0] merge_bits(input logic [STAT_W-1:0] old_v,
                                                     input logic [STAT_W-1:0] new_v,
                                                     input logic [STAT_W-1:0] en);
        return (old_v & ~en) | (new_v & en);
    endfunction

endpackage

// File: rtl/txsched_qstat_bank.sv
module txsched_qstat_bank
    import txsched_regs_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int CMD_Q = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_Q-1:0]        wr_stb,
    input  logic [2*STAT_W-1:0]     wr_word,
    output logic [NUM_Q*STAT_W-1:0] stat_flat
);

    logic [STAT_W-1:0] en_bits;
    logic [STAT_W-1:0] data_bits;

    assign en_bits   = wr_word[2*STAT_W-1:STAT_W];
    assign data_bits = wr_word[STAT_W-1:0];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        qstat_t cur;
        qstat_t nxt;

        always_comb begin
            nxt = cur;
            if (wr_stb[q]) nxt = qstat_t'(merge_bits(cur, data_bits, en_bits));
            if (q == CMD_Q) nxt.ack = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) cur <= '0;
            else     cur <= nxt;
        end

        assign stat_flat[q*STAT_W +: STAT_W] = cur;
    end

endmodule

// File: rtl/txsched_index_bank.sv
module txsched_index_bank #(
    parameter int NUM_Q = 16,
    parameter int IDX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_Q-1:0]       wstb_widx,
    input  logic [NUM_Q-1:0]       wstb_ridx,
    input  logic [IDX_W-1:0]       wr_val,
    input  logic [NUM_Q-1:0]       rd_adv,
    input  logic                   empty_wr,
    input  logic [NUM_Q-1:0]       empty_mask,
    input  logic [NUM_Q-1:0]       empty_data,
    output logic [NUM_Q*IDX_W-1:0] widx_flat,
    output logic [NUM_Q*IDX_W-1:0] ridx_flat,
    output logic [NUM_Q-1:0]       empty
);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [IDX_W-1:0] widx_q, widx_n;
        logic [IDX_W-1:0] ridx_q, ridx_n;
        logic             emp_q, emp_n;

        always_comb begin
            widx_n = wstb_widx[q] ? wr_val : widx_q;
            if (wstb_ridx[q])   ridx_n = wr_val;
            else if (rd_adv[q]) ridx_n = ridx_q + 1'b1;
            else                ridx_n = ridx_q;

            if (ridx_n == widx_n)               emp_n = 1'b1;
            else if (empty_wr && empty_mask[q]) emp_n = empty_data[q];
            else                                emp_n = emp_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                widx_q <= '0;
                ridx_q <= '0;
                emp_q  <= 1'b1;
            end else begin
                widx_q <= widx_n;
                ridx_q <= ridx_n;
                emp_q  <= emp_n;
            end
        end

        assign widx_flat[q*IDX_W +: IDX_W] = widx_q;
        assign ridx_flat[q*IDX_W +: IDX_W] = ridx_q;
        assign empty[q]                    = emp_q;
    end

endmodule

// File: rtl/txsched_chan_map.sv
module txsched_chan_map #(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 8
) (
    input  logic [NUM_Q-1:0]   q_active,
    input  logic [NUM_Q*4-1:0] q_fifo,
    input  logic [NUM_Q-1:0]   q_empty,
    input  logic [NUM_CH-1:0]  chan_en,
    output logic [NUM_Q-1:0]   q_eligible,
    output logic [NUM_CH-1:0]  ch_pending
);

    logic [NUM_Q-1:0] ready;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [3:0] f;
        logic       f_ok;
        assign f    = q_fifo[q*4 +: 4];
        assign f_ok = (int'(f) < NUM_CH);
        assign q_eligible[q] = q_active[q] && f_ok && chan_en[f[$clog2(NUM_CH)-1:0]];
        assign ready[q]      = q_eligible[q] && !q_empty[q];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        always_comb begin
            ch_pending[c] = 1'b0;
            for (int q = 0; q < NUM_Q; q++) begin
                if (ready[q] && int'(q_fifo[q*4 +: 4]) == c) ch_pending[c] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/txsched_regfile.sv
module txsched_regfile
    import txsched_regs_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 8,
    parameter int CMD_Q  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    input  logic [NUM_Q-1:0]    rd_adv,
    output logic [NUM_Q-1:0]    q_active,
    output logic [NUM_Q*4-1:0]  q_fifo,
    output logic [NUM_Q-1:0]    q_win_left,
    output logic [NUM_Q-1:0]    q_ack_mode,
    output logic [NUM_Q-1:0]    q_chain,
    output logic [NUM_Q-1:0]    q_empty,
    output logic [NUM_CH-1:0]   chan_en,
    output logic [NUM_Q-1:0]    q_eligible,
    output logic [NUM_CH-1:0]   ch_pending
);

    dec_t wdec;
    dec_t rdec;

    logic [NUM_Q-1:0] stb_stat, stb_widx, stb_ridx;
    logic             stb_empty, stb_chan, stb_chain;

    logic [NUM_Q*STAT_W-1:0] stat_flat;
    logic [NUM_Q*IDX_W-1:0]  widx_flat;
    logic [NUM_Q*IDX_W-1:0]  ridx_flat;
    logic [NUM_CH-1:0]       chan_q;
    logic [NUM_Q-1:0]        chain_q;
    logic [31:0]             unused_hi;

    assign wdec = decode_addr(wr_addr, NUM_Q);
    assign rdec = decode_addr(rd_addr, NUM_Q);

    always_comb begin
        stb_stat  = '0;
        stb_widx  = '0;
        stb_ridx  = '0;
        stb_empty = wr_en && (wdec.sel == SEL_EMPTY);
        stb_chan  = wr_en && (wdec.sel == SEL_CHAN);
        stb_chain = wr_en && (wdec.sel == SEL_CHAIN);
        if (wr_en) begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (int'(wdec.q) == q) begin
                    stb_stat[q] = (wdec.sel == SEL_STAT);
                    stb_widx[q] = (wdec.sel == SEL_WIDX);
                    stb_ridx[q] = (wdec.sel == SEL_RIDX);
                end
            end
        end
    end

    txsched_qstat_bank #(.NUM_Q(NUM_Q), .CMD_Q(CMD_Q)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (stb_stat),
        .wr_word  (wr_data[2*STAT_W-1:0]),
        .stat_flat(stat_flat)
    );

    txsched_index_bank #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_idx (
        .clk       (clk),
        .rst       (rst),
        .wstb_widx (stb_widx),
        .wstb_ridx (stb_ridx),
        .wr_val    (wr_data[IDX_W-1:0]),
        .rd_adv    (rd_adv),
        .empty_wr  (stb_empty),
        .empty_mask(wr_data[16 +: NUM_Q]),
        .empty_data(wr_data[NUM_Q-1:0]),
        .widx_flat (widx_flat),
        .ridx_flat (ridx_flat),
        .empty     (q_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q  <= '0;
            chain_q <= '0;
        end else begin
            if (stb_chan)  chan_q  <= wr_data[NUM_CH-1:0];
            if (stb_chain) chain_q <= wr_data[NUM_Q-1:0];
        end
    end

    assign chan_en = chan_q;
    assign q_chain = chain_q;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_dec
        qstat_t s;
        assign s                = qstat_t'(stat_flat[q*STAT_W +: STAT_W]);
        assign q_active[q]      = s.active;
        assign q_fifo[q*4 +: 4] = s.fifo;
        assign q_win_left[q]    = s.win_left;
        assign q_ack_mode[q]    = s.ack;
    end

    txsched_chan_map #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH)) u_map (
        .q_active  (q_active),
        .q_fifo    (q_fifo),
        .q_empty   (q_empty),
        .chan_en   (chan_q),
        .q_eligible(q_eligible),
        .ch_pending(ch_pending)
    );

    assign unused_hi = '0;

    always_comb begin
        rd_data = unused_hi;
        unique case (rdec.sel)
            SEL_EMPTY: rd_data = 32'(q_empty);
            SEL_CHAN:  rd_data = 32'(chan_q);
            SEL_CHAIN: rd_data = 32'(chain_q);
            SEL_WIDX:  rd_data = 32'(widx_flat[rdec.q*IDX_W +: IDX_W]);
            SEL_RIDX:  rd_data = 32'(ridx_flat[rdec.q*IDX_W +: IDX_W]);
            SEL_STAT:  rd_data = 32'(stat_flat[rdec.q*STAT_W +: STAT_W]);
            default:   rd_data = unused_hi;
        endcase
    end

endmodule

// File: rtl/txsched_regfile_chk.sv
module txsched_regfile_chk #(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 8,
    parameter int CMD_Q  = 4,
    parameter int STAT_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [NUM_Q-1:0]        rd_adv,
    input logic [NUM_Q-1:0]        q_active,
    input logic [NUM_Q-1:0]        q_ack_mode,
    input logic [NUM_Q-1:0]        q_empty,
    input logic [NUM_Q-1:0]        q_eligible,
    input logic [NUM_CH-1:0]       ch_pending,
    input logic [NUM_Q*STAT_W-1:0] stat_flat,
    input logic [NUM_Q*IDX_W-1:0]  widx_flat,
    input logic [NUM_Q*IDX_W-1:0]  ridx_flat
);

    // R4: the command queue never leaves FIFO mode
    p_cmd_fifo_r4: assert property (@(posedge clk) disable iff (rst)
        !q_ack_mode[CMD_Q]);

    // R2: status words move only on a write
    p_stat_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(stat_flat));

    // R12: a pending channel needs a ready queue behind it
    p_pending_src_r12: assert property (@(posedge clk) disable iff (rst)
        (ch_pending != '0) |-> ((q_eligible & ~q_empty) != '0));

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        // R11: only active queues are eligible
        p_elig_active_r11: assert property (@(posedge clk) disable iff (rst)
            q_eligible[q] |-> q_active[q]);

        // R9: equal indices imply empty
        p_eq_empty_r9: assert property (@(posedge clk) disable iff (rst)
            (ridx_flat[q*IDX_W +: IDX_W] == widx_flat[q*IDX_W +: IDX_W]) |-> q_empty[q]);

        // R7: read index wraps to zero
        p_rd_wrap_r7: assert property (@(posedge clk) disable iff (rst)
            (!wr_en && rd_adv[q] && (&ridx_flat[q*IDX_W +: IDX_W]))
            |=> (ridx_flat[q*IDX_W +: IDX_W] == '0));
    end

endmodule

bind txsched_regfile txsched_regfile_chk #(
    .NUM_Q (NUM_Q),
    .NUM_CH(NUM_CH),
    .IDX_W (IDX_W),
    .CMD_Q (CMD_Q),
    .STAT_W(10)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_adv    (rd_adv),
    .q_active  (q_active),
    .q_ack_mode(q_ack_mode),
    .q_empty   (q_empty),
    .q_eligible(q_eligible),
    .ch_pending(ch_pending),
    .stat_flat (stat_flat),
    .widx_flat (widx_flat),
    .ridx_flat (ridx_flat)
);

// File: tb/txsched_regfile_bench.sv
module txsched_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] rd_adv = '0;
    logic [15:0] q_active, q_win_left, q_ack_mode, q_chain, q_empty, q_eligible;
    logic [63:0] q_fifo;
    logic [7:0]  chan_en, ch_pending;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    txsched_regfile u_txsched_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_adv(rd_adv),
        .q_active(q_active), .q_fifo(q_fifo), .q_win_left(q_win_left),
        .q_ack_mode(q_ack_mode), .q_chain(q_chain), .q_empty(q_empty),
        .chan_en(chan_en), .q_eligible(q_eligible), .ch_pending(ch_pending)
    );

    // {write addr, write data, read addr, expected, requirement number}
    localparam int NV = 12;
    localparam logic [91:0] VEC [NV] = '{
        {10'h100, 32'h000FFC05, 10'h100, 32'h00000005, 8'd1},  // R1 full write
        {10'h100, 32'h00040100, 10'h100, 32'h00000105, 8'd2},  // R2 only bit 8 enabled
        {10'h100, 32'h000003FF, 10'h100, 32'h00000105, 8'd2},  // R2 no enables
        {10'h110, 32'h000FFD01, 10'h110, 32'h00000001, 8'd4},  // R4 queue 4 ack dropped
        {10'h004, 32'hFFFFFFA5, 10'h004, 32'h000000A5, 8'd5},  // R5
        {10'h008, 32'hABCD1234, 10'h008, 32'h00001234, 8'd6},  // R6
        {10'h04C, 32'h000001FF, 10'h04C, 32'h000000FF, 8'd7},  // R7 write index q3
        {10'h000, 32'h00080000, 10'h000, 32'h0000FFF7, 8'd8},  // R8 clear q3 flag
        {10'h000, 32'h00200000, 10'h000, 32'h0000FFF7, 8'd9},  // R9 q5 equal, stays set
        {10'h08C, 32'h000000FF, 10'h000, 32'h0000FFFF, 8'd9},  // R9 q3 indices meet
        {10'h3FC, 32'hFFFFFFFF, 10'h3FC, 32'h00000000, 8'd10}, // R10 unmapped
        {10'h101, 32'h000FFC00, 10'h100, 32'h00000105, 8'd10}  // R10 misaligned write
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 / R8 reset state
        rd(10'h000, v); check("R8 reset empty", v, 32'h0000FFFF);
        rd(10'h100, v); check("R10 reset status", v, 32'h0);
        check("R10 reset active", 32'(q_active), 32'h0);
        check("R12 reset pending", 32'(ch_pending), 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][91:82], VEC[i][81:50]);
            rd(VEC[i][49:40], v);
            total++;
            if (v !== VEC[i][39:8]) begin
                bad++;
                $display("FAIL R%0d vector %0d: got %h expected %h", VEC[i][7:0], i, v, VEC[i][39:8]);
            end
        end

        // R3 field decode on queue 0 (0x105: active, fifo 2, ack)
        check("R3 active", 32'(q_active[0]), 32'h1);
        check("R3 fifo", 32'(q_fifo[3:0]), 32'h2);
        check("R3 ack", 32'(q_ack_mode[0]), 32'h1);
        check("R3 win", 32'(q_win_left[0]), 32'h0);
        wr(10'h100, 32'h00008020);
        check("R3 win set", 32'(q_win_left[0]), 32'h1);
        check("R4 ack out", 32'(q_ack_mode[4]), 32'h0);
        check("R6 chain out", 32'(q_chain), 32'h1234);

        // R11: chan 0xA5 enables 0 and 2; q0 on 2, q4 on 0
        check("R11 eligible", 32'(q_eligible), 32'h0011);
        check("R12 all empty", 32'(ch_pending), 32'h0);
        wr(10'h000, 32'h00010000);           // set q0 wr index differs? no: indices equal
        check("R9 q0 equal keeps empty", 32'(q_empty), 32'hFFFF);
        wr(10'h040, 32'h00000003);           // q0 write index 3
        wr(10'h000, 32'h00010000);           // clear q0 flag
        check("R8 q0 cleared", 32'(q_empty), 32'hFFFE);
        check("R12 ch2 pending", 32'(ch_pending), 32'h04);
        wr(10'h004, 32'h000000A1);
        check("R11 ch2 off", 32'(q_eligible), 32'h0010);
        check("R12 ch2 off", 32'(ch_pending), 32'h00);
        wr(10'h004, 32'h000000FF);
        wr(10'h100, 32'h00007812);           // q0 fifo field 9
        check("R3 fifo 9", 32'(q_fifo[3:0]), 32'h9);
        check("R11 fifo out of range", 32'(q_eligible), 32'h0010);

        // R7 wrap: q3 read index 0xFF
        @(negedge clk); rd_adv = 16'h0008;
        @(negedge clk); rd_adv = '0;
        rd(10'h08C, v); check("R7 wrap", v, 32'h0);
        // R7 write wins over advance
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'h08C; wr_data = 32'h10; rd_adv = 16'h0008;
        @(negedge clk);
        wr_en = 1'b0; rd_adv = '0;
        rd(10'h08C, v); check("R7 write priority", v, 32'h10);

        // R9: q3 write index 0x11, clear flag, then advance to match
        wr(10'h04C, 32'h00000011);
        wr(10'h000, 32'h00080000);
        check("R8 q3 cleared", 32'(q_empty[3]), 32'h0);
        @(negedge clk); rd_adv = 16'h0008;
        @(negedge clk); rd_adv = '0;
        check("R9 q3 meets", 32'(q_empty[3]), 32'h1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule